// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

The block watches a 32-bit vector of already synchronised inputs, split into four 8-bit banks: three banks of isolated inputs and one bank of TTL lines. Each bank can be armed for rising edges, for falling edges, or for both. An edge is found by comparing each input with its value one clock earlier. When an armed edge arrives, the matching status bit is set and stays set until software clears it.

Software reaches the block through a simple write port. Each write carries a word address and four byte enables. The status bytes live in one 32-bit word at byte address 8, in little-endian order. Writing ones to a status byte clears those bits. The arming bits sit in one byte at byte address 12. One level interrupt line is raised while any status bit is set. The full state is shown on output ports, so the surrounding register bank can offer it to the host for reading.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, all status bits are 0, the enable byte is 0, the interrupt is low, and every stored previous input value is 0.
- R2: Input bit n is in bank n/8. With the bank's rising enable set, a 0-to-1 change on input n sets status bit n at the next clock edge.
- R3: With the bank's falling enable set, a 1-to-0 change on input n sets status bit n at the next clock edge.
- R4: Enable bit b (b = 0..3) arms rising edges for bank b, and enable bit 4+b arms falling edges for bank b. An edge whose direction is not armed sets nothing.
- R5: A bank whose rising and falling enables are both 0 never sets any of its status bits.
- R6: A set status bit stays set after its input returns to its earlier level. It is cleared only by a clear write.
- R7: Byte lane k is wr_data_i[8k+7:8k], and it is used when wr_be_i[k] is 1. A write to word address 2 with a single lane k enabled clears exactly the status bits of bank k that are written as 1. All other bits keep their value.
- R8: A write to word address 2 with all four lanes enabled clears status bits across all four banks in one cycle. Status bit n maps to wr_data_i bit n (little-endian).
- R9: If an armed edge and a clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R10: irq_o is 1 exactly when at least one status bit is 1.
- R11: An input held at a constant level causes no further status setting. A bit cleared while its input stays high remains 0.
- R12: A write to word address 3 with lane 0 enabled loads the enable byte from wr_data_i[7:0], and enable_o shows it. Writes to any other word address, and lanes 1 to 3 of word 3, change neither the enable byte nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_in_i | input | 32 | Synchronised inputs, bank b on bits 8b+7..8b |
| wr_i | input | 1 | Write strobe |
| wr_word_i | input | 2 | Word address (byte address / 4) |
| wr_data_i | input | 32 | Write data, four byte lanes |
| wr_be_i | input | 4 | Byte-lane enables |
| status_o | output | 32 | Sticky change-of-state status, bit n for input n |
| enable_o | output | 8 | Edge enable byte |
| irq_o | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench first arms a single bank for rising edges only. It then sweeps all inputs up and down, which separates the rising arm from the falling arm and shows that unarmed banks stay quiet. It also arms one bank for both directions, which shows the bank decoding is per bank rather than global. Clear writes are issued as single-lane byte writes and as full-word writes, which separates lane selection from the little-endian bit mapping. A clear issued in the same cycle as an armed edge, and a clear issued while an input is held high, separate edge-wins priority from level sensitivity.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  localparam int unsigned BANK_W      = 8;
  localparam int unsigned NUM_BANKS   = 4;
  localparam int unsigned WORD_AW     = 2;
  localparam int unsigned STATUS_WORD = 2;
  localparam int unsigned ENABLE_WORD = 3;
  localparam int unsigned ENABLE_LANE = 0;
endpackage

// File: rtl/cos_edge_detect.sv
module cos_edge_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  assign rise_o = in_i & ~prev_q;
  assign fall_o = ~in_i & prev_q;
endmodule

// File: rtl/cos_enable_reg.sv
module cos_enable_reg #(
  parameter int unsigned NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2*NB-1:0] data_i,
  output logic [2*NB-1:0] en_o,
  output logic [NB-1:0] rise_en_o,
  output logic [NB-1:0] fall_en_o
);
  logic [2*NB-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= data_i;
  end

  assign en_o      = en_q;
  assign rise_en_o = en_q[NB-1:0];
  assign fall_en_o = en_q[2*NB-1:NB];

  // R12: enable only moves on its own write
  a_r12_enable_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/cos_status_bank.sv
module cos_status_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic         rise_en_i,
  input  logic         fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] hit;
  logic [W-1:0] status_q;

  assign hit = (rise_i & {W{rise_en_i}}) | (fall_i & {W{fall_en_i}});

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit;
  end

  assign status_o = status_q;

  a_r9_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_en_i && ((rise_i & clr_i) != '0)) |=>
      ((status_o & $past(rise_i & clr_i)) == $past(rise_i & clr_i)));

  a_r5_bank_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_en_i && !fall_en_i) |=> ((status_o & ~$past(status_o)) == '0));

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~rise_i & ~fall_i) != '0) |=>
      ((status_o & $past(clr_i & ~rise_i & ~fall_i)) == '0));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS_P   = NUM_BANKS,
  parameter int unsigned BANK_W_P      = BANK_W,
  parameter int unsigned WORD_AW_P     = WORD_AW,
  parameter int unsigned STATUS_WORD_P = STATUS_WORD,
  parameter int unsigned ENABLE_WORD_P = ENABLE_WORD,
  parameter int unsigned ENABLE_LANE_P = ENABLE_LANE
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_BANKS_P*BANK_W_P-1:0]   sync_in_i,
  input  logic                              wr_i,
  input  logic [WORD_AW_P-1:0]              wr_word_i,
  input  logic [NUM_BANKS_P*BANK_W_P-1:0]   wr_data_i,
  input  logic [NUM_BANKS_P-1:0]            wr_be_i,
  output logic [NUM_BANKS_P*BANK_W_P-1:0]   status_o,
  output logic [2*NUM_BANKS_P-1:0]          enable_o,
  output logic                              irq_o
);
  localparam int unsigned IN_W = NUM_BANKS_P * BANK_W_P;
  localparam int unsigned EN_W = 2 * NUM_BANKS_P;
  localparam logic [WORD_AW_P-1:0] STAT_A = STATUS_WORD_P[WORD_AW_P-1:0];
  localparam logic [WORD_AW_P-1:0] EN_A   = ENABLE_WORD_P[WORD_AW_P-1:0];

  logic [IN_W-1:0]        rise_v, fall_v;
  logic [NUM_BANKS_P-1:0] rise_en, fall_en;
  logic                   stat_sel, en_wr;

  assign stat_sel = wr_i && (wr_word_i == STAT_A);
  assign en_wr    = wr_i && (wr_word_i == EN_A) && wr_be_i[ENABLE_LANE_P];

  cos_edge_detect #(.W(IN_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (sync_in_i),
    .rise_o (rise_v),
    .fall_o (fall_v)
  );

  cos_enable_reg #(.NB(NUM_BANKS_P)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (en_wr),
    .data_i    (wr_data_i[ENABLE_LANE_P*BANK_W_P +: EN_W]),
    .en_o      (enable_o),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en)
  );

  for (genvar b = 0; b < NUM_BANKS_P; b++) begin : g_bank
    logic [BANK_W_P-1:0] clr;
    assign clr = (stat_sel && wr_be_i[b]) ? wr_data_i[b*BANK_W_P +: BANK_W_P] : '0;

    cos_status_bank #(.W(BANK_W_P)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise_v[b*BANK_W_P +: BANK_W_P]),
      .fall_i    (fall_v[b*BANK_W_P +: BANK_W_P]),
      .rise_en_i (rise_en[b]),
      .fall_en_i (fall_en[b]),
      .clr_i     (clr),
      .status_o  (status_o[b*BANK_W_P +: BANK_W_P])
    );
  end

  assign irq_o = |status_o;

  // R10: interrupt only rises after an edge was seen
  a_r10_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((rise_v | fall_v) != '0));

  // R12: foreign writes leave status untouched unless an edge arrives
  a_r12_no_side_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_sel) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: tb/tb_cos_irq_ctrl.sv
module tb_cos_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sync_in = '0;
  logic        wr = 1'b0;
  logic [1:0]  wr_word = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] status;
  logic [7:0]  enable;
  logic        irq;

  always #2 clk = ~clk;

  cos_irq_ctrl dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sync_in_i (sync_in),
    .wr_i      (wr),
    .wr_word_i (wr_word),
    .wr_data_i (wr_data),
    .wr_be_i   (wr_be),
    .status_o  (status),
    .enable_o  (enable),
    .irq_o     (irq)
  );

  typedef struct {
    logic [31:0] st;
    logic [7:0]  en;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [31:0] m_st = '0;
  logic [7:0]  m_en = '0;
  logic [31:0] m_prev = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compare results at the falling edge after they appear
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "status", status, e.st);
        chk(e.tag, "enable", {24'h0, enable}, {24'h0, e.en});
        chk(e.tag, "irq", {31'h0, irq}, {31'h0, |e.st});
      end
    end
  end

  // driver: apply one cycle, update the reference model, queue expectation
  task automatic drive(input logic [31:0] din, input logic w, input logic [1:0] word,
                       input logic [31:0] data, input logic [3:0] be, input string tag);
    logic [31:0] rise, fall, hit, clr;
    exp_t e;
    @(negedge clk);
    sync_in = din; wr = w; wr_word = word; wr_data = data; wr_be = be;
    rise = din & ~m_prev;
    fall = ~din & m_prev;
    hit = '0; clr = '0;
    for (int b = 0; b < 4; b++) begin
      hit[b*8 +: 8] = (rise[b*8 +: 8] & {8{m_en[b]}}) | (fall[b*8 +: 8] & {8{m_en[b+4]}});
      if (w && word == 2'd2 && be[b]) clr[b*8 +: 8] = data[b*8 +: 8];
    end
    m_st = (m_st & ~clr) | hit;
    if (w && word == 2'd3 && be[0]) m_en = data[7:0];
    m_prev = din;
    @(posedge clk);
    #1;
    e.st = m_st; e.en = m_en; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic [31:0] din, input string tag);
    drive(din, 1'b0, 2'd0, 32'h0, 4'h0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(32'h0, "R1");
    // arm bank 0 rising only
    drive(32'h0, 1'b1, 2'd3, 32'h0000_0001, 4'b0001, "R12");
    idle(32'hFFFF_FFFF, "R2");                   // only bank 0 sets
    idle(32'hFFFF_FFFF, "R6");
    drive(32'hFFFF_FFFF, 1'b1, 2'd2, 32'h0000_000F, 4'b0001, "R7");
    idle(32'hFFFF_FFFF, "R11");                  // held high: no re-set
    idle(32'h0, "R4");                           // falling not armed
    // arm falling on all banks
    drive(32'h0, 1'b1, 2'd3, 32'h0000_00F0, 4'b0001, "R12");
    idle(32'hFFFF_FFFF, "R4");                   // rising not armed
    idle(32'h0, "R3");
    idle(32'h0, "R6");
    drive(32'h0, 1'b1, 2'd2, 32'hFFFF_FFFF, 4'b1111, "R8");
    idle(32'h0, "R10");
    // bank 1 both directions only
    drive(32'h0, 1'b1, 2'd3, 32'h0000_0022, 4'b0001, "R12");
    idle(32'hFFFF_FFFF, "R5");
    idle(32'h0, "R5");
    // partial word clear on bank 1 via lane 1
    drive(32'h0, 1'b1, 2'd2, 32'h0000_3C00, 4'b0010, "R7");
    // arm all, then edge and clear together
    drive(32'h0, 1'b1, 2'd3, 32'h0000_00FF, 4'b0001, "R12");
    drive(32'h0001_0000, 1'b1, 2'd2, 32'hFFFF_FFFF, 4'b1111, "R9");
    drive(32'h0001_0000, 1'b1, 2'd2, 32'h00FF_0000, 4'b0100, "R7");
    idle(32'h8000_0000, "R2");                   // bit 31 up, bit 16 down
    drive(32'h8000_0000, 1'b1, 2'd1, 32'hFFFF_FFFF, 4'b1111, "R12");
    drive(32'h8000_0000, 1'b1, 2'd3, 32'h0000_0000, 4'b1110, "R12");
    drive(32'h8000_0000, 1'b1, 2'd2, 32'h0000_0000, 4'b1111, "R7");
    drive(32'h8000_0000, 1'b1, 2'd2, 32'hFF01_0000, 4'b1100, "R8");
    idle(32'h8000_0000, "R10");
    idle(32'h0, "R3");
    drive(32'h0, 1'b1, 2'd2, 32'h8000_0000, 4'b1000, "R10");
    idle(32'h0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule